// File: doc/BRIEF.md
# Prioritised Interrupt Distributor

This block gathers interrupt lines from peripherals and keeps a separate lifecycle for each line. A line is idle, pending, active (taken by the processor and being serviced), or active with a further pending instance behind it. Each source has an enable bit, an 8-bit priority, a group bit and a trigger-mode bit. Each of the two groups also has a global distribution switch. From all sources that are pending, enabled and in an open group, the block picks one and shows its identifier and priority to one processor-side port. The pick goes to the numerically lowest priority value, and the lowest identifier wins a tie.

The processor takes the presented interrupt by pulsing `ack`, which acts on whatever source `hp_id` shows in that cycle. When service is finished, it pulses `deact` with the source's identifier. Settings arrive through a one-cycle write port. A select code picks the target. Enable bits have their own set and clear actions, so changing one source never disturbs another.

Top module: `irq_distributor`

## Requirements
- R1: After reset, every source is idle and disabled, both group switches are off, all groups are 0, all trigger modes are level and all priorities are 0. A line raised before any configuration is therefore never presented.
- R2: A level-mode source whose line is high becomes pending on the next clock edge, and its identifier is visible at the outputs right after that edge. If the line falls before the source is taken, the pending state clears on the next edge.
- R3: Taking a level source whose line is still high makes it active-and-pending, and it is not presented again. If its line then falls it becomes active. Deactivation moves active to idle, and moves active-and-pending to pending.
- R4: An edge-mode source becomes pending on a low-to-high transition and stays pending after the line falls. Taking it makes it active. A new rising edge while active makes it active-and-pending. Deactivation then returns it to pending.
- R5: Among eligible sources the lowest priority value wins. Equal values go to the lowest identifier. Priority 0xFF is an ordinary value.
- R6: Select 0 sets the enable bits that are 1 in `cfg_wdata`, and select 1 clears them. Bits written as 0 leave their enable unchanged. A disabled source is never presented.
- R7: Select 2 writes the group bits (1 = group 1). Select 5 writes the group switches (bit 0 = group 0, bit 1 = group 1). A source in a switched-off group is never presented.
- R8: `ack` acts only on the source shown by `hp_id` while `irq_req` is high. That source is not presented again until it is deactivated.
- R9: With no eligible source, `irq_req` is 0, `hp_id` is all ones and `hp_prio` is all ones.
- R10: Select 3 writes the trigger bits (1 = edge). Select 4 writes `cfg_wdata[PRIO_W-1:0]` as the priority of source `cfg_idx`. Selects 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | NUM_SRC | Interrupt lines from peripherals, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select |
| cfg_idx | input | IDX_W | Source index for priority writes |
| cfg_wdata | input | DATA_W | Configuration write data |
| ack | input | 1 | Take the presented source |
| deact | input | 1 | Deactivate the source named by `deact_id` |
| deact_id | input | ID_W | Identifier to deactivate |
| irq_req | output | 1 | An eligible source is presented |
| hp_id | output | ID_W | Presented identifier, or all ones |
| hp_prio | output | PRIO_W | Presented priority, or all ones |

## Verification
The assertions check four things on every cycle. The output is spurious exactly when nothing is requested. A presented identifier is in range, enabled and in an open group. A taken source does not reappear on the following cycle. Only the bench's scenarios can show the lifecycle order: active-and-pending falling to active when a level line drops, edge latching that survives the line falling, and deactivation returning a source to pending or to idle. The same holds for the tie-breaking order, the set and clear semantics of the enable writes, and the claim that the unused selects change nothing.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

   typedef enum logic [1:0] {
      SRC_IDLE    = 2'b00,
      SRC_PEND    = 2'b01,
      SRC_ACT     = 2'b10,
      SRC_ACTPEND = 2'b11
   } src_state_e;

   typedef enum logic [2:0] {
      SEL_SETEN  = 3'd0,
      SEL_CLREN  = 3'd1,
      SEL_GROUP  = 3'd2,
      SEL_TRIG   = 3'd3,
      SEL_PRIO   = 3'd4,
      SEL_GLOBAL = 3'd5
   } cfg_sel_e;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
   import irq_dist_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic edge_mode,
   input  logic take,
   input  logic retire,
   output logic pend_out
);

   src_state_e state_q, state_d;
   logic       line_q;
   logic       rise;
   logic       evt;

   assign rise = line & ~line_q;
   assign evt  = edge_mode ? rise : line;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SRC_IDLE: begin
            if (evt) state_d = SRC_PEND;
         end
         SRC_PEND: begin
            if (take)
               state_d = (!edge_mode && line) ? SRC_ACTPEND : SRC_ACT;
            else if (!edge_mode && !line)
               state_d = SRC_IDLE;
         end
         SRC_ACT: begin
            if (retire)
               state_d = evt ? SRC_PEND : SRC_IDLE;
            else if (evt)
               state_d = SRC_ACTPEND;
         end
         default: begin
            if (retire)
               state_d = (edge_mode || line) ? SRC_PEND : SRC_IDLE;
            else if (!edge_mode && !line)
               state_d = SRC_ACT;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SRC_IDLE;
         line_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         line_q  <= line;
      end
   end

   assign pend_out = (state_q == SRC_PEND);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 8,
   parameter int ID_W    = 4
) (
   input  logic [NUM_SRC-1:0]             elig,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   output logic                           found,
   output logic [ID_W-1:0]                win_id,
   output logic [PRIO_W-1:0]              win_prio
);

   always_comb begin
      found    = 1'b0;
      win_id   = '1;
      win_prio = '1;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig[i] && (!found || (prio[i] < win_prio))) begin
            found    = 1'b1;
            win_id   = ID_W'(i);
            win_prio = prio[i];
         end
      end
   end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import irq_dist_pkg::*;
#(
   parameter  int NUM_SRC = 8,
   parameter  int PRIO_W  = 8,
   localparam int ID_W    = $clog2(NUM_SRC + 1),
   localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int DATA_W  = (NUM_SRC > PRIO_W) ? NUM_SRC : PRIO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_line,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_sel,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [DATA_W-1:0]  cfg_wdata,
   input  logic               ack,
   input  logic               deact,
   input  logic [ID_W-1:0]    deact_id,
   output logic               irq_req,
   output logic [ID_W-1:0]    hp_id,
   output logic [PRIO_W-1:0]  hp_prio
);

   if (NUM_SRC < 2) begin : g_bad_num
      $error("irq_distributor: NUM_SRC must be at least 2");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("irq_distributor: PRIO_W must be at least 1");
   end

   logic [NUM_SRC-1:0]             en_q;
   logic [NUM_SRC-1:0]             grp_q;
   logic [NUM_SRC-1:0]             trig_q;
   logic [1:0]                     grp_en_q;
   logic [PRIO_W-1:0]              prio_q [NUM_SRC];
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_flat;
   logic [NUM_SRC-1:0]             pend;
   logic [NUM_SRC-1:0]             elig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         grp_q    <= '0;
         trig_q   <= '0;
         grp_en_q <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_SETEN:  en_q     <= en_q | cfg_wdata[NUM_SRC-1:0];
            SEL_CLREN:  en_q     <= en_q & ~cfg_wdata[NUM_SRC-1:0];
            SEL_GROUP:  grp_q    <= cfg_wdata[NUM_SRC-1:0];
            SEL_TRIG:   trig_q   <= cfg_wdata[NUM_SRC-1:0];
            SEL_GLOBAL: grp_en_q <= cfg_wdata[1:0];
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic take_i;
      logic retire_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_q[i] <= '0;
         else if (cfg_we && (cfg_sel == SEL_PRIO) && (cfg_idx == IDX_W'(i)))
            prio_q[i] <= cfg_wdata[PRIO_W-1:0];
      end

      assign prio_flat[i] = prio_q[i];
      assign take_i       = ack && irq_req && (hp_id == ID_W'(i));
      assign retire_i     = deact && (deact_id == ID_W'(i));

      irq_src_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .line      (irq_line[i]),
         .edge_mode (trig_q[i]),
         .take      (take_i),
         .retire    (retire_i),
         .pend_out  (pend[i])
      );

      assign elig[i] = pend[i] & en_q[i] & grp_en_q[grp_q[i]];
   end

   irq_prio_pick #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W)
   ) u_pick (
      .elig     (elig),
      .prio     (prio_flat),
      .found    (irq_req),
      .win_id   (hp_id),
      .win_prio (hp_prio)
   );

endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 8,
   parameter int ID_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ack,
   input logic               irq_req,
   input logic [ID_W-1:0]    hp_id,
   input logic [PRIO_W-1:0]  hp_prio,
   input logic [NUM_SRC-1:0] src_en,
   input logic [NUM_SRC-1:0] src_grp,
   input logic [1:0]         grp_en
);

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [ID_W-1:0] SPUR = {ID_W{1'b1}};

   logic [IDX_W-1:0] hp_idx;
   assign hp_idx = hp_id[IDX_W-1:0];

   // R9
   a_r9_spurious_out: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (hp_id == SPUR) && (hp_prio == {PRIO_W{1'b1}}));

   // R9
   a_r9_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (hp_id < ID_W'(NUM_SRC)));

   // R6
   a_r6_presented_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> src_en[hp_idx]);

   // R7
   a_r7_group_open: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> grp_en[src_grp[hp_idx]]);

   // R8
   a_r8_no_retake: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_req) |=> (hp_id != $past(hp_id)));

endmodule

bind irq_distributor irq_distributor_chk #(
   .NUM_SRC (NUM_SRC),
   .PRIO_W  (PRIO_W),
   .ID_W    (ID_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ack     (ack),
   .irq_req (irq_req),
   .hp_id   (hp_id),
   .hp_prio (hp_prio),
   .src_en  (en_q),
   .src_grp (grp_q),
   .grp_en  (grp_en_q)
);

// File: tb/irq_distributor_test.sv
`timescale 1ns/1ps
module irq_distributor_test;

   localparam int N  = 8;
   localparam int PW = 8;
   localparam int IW = 4;
   localparam int XW = 3;
   localparam int DW = 8;
   localparam logic [IW-1:0] SPUR = 4'hF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_line = '0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_sel = '0;
   logic [XW-1:0] cfg_idx = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          ack = 1'b0;
   logic          deact = 1'b0;
   logic [IW-1:0] deact_id = '0;
   logic          irq_req;
   logic [IW-1:0] hp_id;
   logic [PW-1:0] hp_prio;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_distributor #(.NUM_SRC(N), .PRIO_W(PW)) uut (
      .clk, .rst_n, .irq_line, .cfg_we, .cfg_sel, .cfg_idx, .cfg_wdata,
      .ack, .deact, .deact_id, .irq_req, .hp_id, .hp_prio
   );

   // {lines, expected id, expected priority}
   localparam logic [19:0] VEC [10] = '{
      {8'h01, 4'h0, 8'h40},
      {8'h03, 4'h1, 8'h10},
      {8'h0A, 4'h1, 8'h10},
      {8'h08, 4'h3, 8'h10},
      {8'h48, 4'h3, 8'h10},
      {8'h40, 4'h6, 8'hFF},
      {8'hC0, 4'h7, 8'h05},
      {8'hFF, 4'h7, 8'h05},
      {8'h30, 4'h5, 8'h20},
      {8'h00, 4'hF, 8'hFF}
   };
   localparam logic [7:0] PRIOS [8] = '{8'h40, 8'h10, 8'h30, 8'h10,
                                        8'h80, 8'h20, 8'hFF, 8'h05};

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_id(string req, logic [IW-1:0] exp_id);
      logic exp_req;
      exp_req = (exp_id != SPUR);
      checks++;
      if (hp_id !== exp_id || irq_req !== exp_req) begin
         errors++;
         $display("FAIL %s: id=%0h req=%0b expected id=%0h req=%0b",
                  req, hp_id, irq_req, exp_id, exp_req);
      end
   endtask

   task automatic expect_prio(string req, logic [PW-1:0] exp_p);
      checks++;
      if (hp_prio !== exp_p) begin
         errors++;
         $display("FAIL %s: prio=%0h expected prio=%0h", req, hp_prio, exp_p);
      end
   endtask

   task automatic wr(logic [2:0] sel, logic [XW-1:0] idx, logic [DW-1:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = data;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic take();
      ack = 1'b1;
      tick();
      ack = 1'b0;
   endtask

   task automatic retire(logic [IW-1:0] id);
      deact = 1'b1; deact_id = id;
      tick();
      deact = 1'b0;
   endtask

   task automatic lines(logic [N-1:0] v);
      irq_line = v;
      tick();
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      repeat (3) tick();
      expect_id("R1 reset outputs", SPUR);
      expect_prio("R9 reset priority", 8'hFF);
      rst_n = 1'b1;
      tick();
      lines(8'h01);
      expect_id("R1 disabled after reset", SPUR);

      // configuration: group 0 open, all enabled, priorities
      wr(3'd5, '0, 8'h01);
      wr(3'd0, '0, 8'hFF);
      for (int i = 0; i < N; i++) wr(3'd4, XW'(i), PRIOS[i]);
      expect_id("R2 pending becomes visible", 4'h0);
      lines(8'h00);
      expect_id("R2 level drop clears pending", SPUR);

      // table of level patterns
      for (int k = 0; k < 10; k++) begin
         lines(VEC[k][19:12]);
         expect_id("R5 arbitration vector", VEC[k][11:8]);
         expect_prio("R5 arbitration priority", VEC[k][7:0]);
      end

      // R6 set/clear enables
      lines(8'h01);
      wr(3'd1, '0, 8'h00);
      expect_id("R6 clear with zero no effect", 4'h0);
      wr(3'd1, '0, 8'h01);
      expect_id("R6 cleared source hidden", SPUR);
      wr(3'd0, '0, 8'h00);
      expect_id("R6 set with zero no effect", SPUR);
      wr(3'd0, '0, 8'h01);
      expect_id("R6 set restores source", 4'h0);

      // R10 unused selects
      wr(3'd7, '0, 8'hFF);
      expect_id("R10 select 7 ignored", 4'h0);
      wr(3'd6, '0, 8'h00);
      expect_id("R10 select 6 ignored", 4'h0);

      // R7 groups
      wr(3'd2, '0, 8'h01);
      expect_id("R7 group 1 closed", SPUR);
      wr(3'd5, '0, 8'h03);
      expect_id("R7 group 1 opened", 4'h0);
      wr(3'd5, '0, 8'h02);
      expect_id("R7 group 0 closed, group 1 open", 4'h0);
      wr(3'd2, '0, 8'h00);
      expect_id("R7 source moved to closed group 0", SPUR);
      wr(3'd5, '0, 8'h03);
      lines(8'h00);
      expect_id("R7 idle after restore", SPUR);

      // R5 tie at 0xFF and priority rewrite (R10)
      wr(3'd4, 3'd7, 8'hFF);
      lines(8'hC0);
      expect_id("R5 tie goes to lower id", 4'h6);
      expect_prio("R5 tie priority", 8'hFF);
      wr(3'd4, 3'd7, 8'h00);
      expect_id("R10 priority rewrite", 4'h7);
      expect_prio("R10 rewritten priority", 8'h00);
      lines(8'h00);

      // R3 level lifecycle on source 2
      lines(8'h04);
      expect_id("R3 level source pending", 4'h2);
      take();
      expect_id("R3 taken while high is hidden", SPUR);
      tick();
      expect_id("R3 active-and-pending stays hidden", SPUR);
      retire(4'h2);
      expect_id("R3 deact of active-and-pending gives pending", 4'h2);
      take();
      lines(8'h00);
      expect_id("R3 line drop leaves active", SPUR);
      retire(4'h2);
      expect_id("R3 deact of active gives idle", SPUR);
      lines(8'h04);
      expect_id("R3 fresh assertion after idle", 4'h2);
      lines(8'h00);

      // R8 ack targets only the presented source
      lines(8'h05);
      expect_id("R8 best of two", 4'h2);
      take();
      expect_id("R8 next source after take", 4'h0);
      retire(4'h2);
      expect_id("R8 retired source back on top", 4'h2);
      lines(8'h00);
      expect_id("R8 all lines low", SPUR);
      take();
      expect_id("R8 ack with nothing presented", SPUR);

      // R4 edge lifecycle on source 4
      wr(3'd3, '0, 8'h10);
      lines(8'h10);
      expect_id("R4 rising edge pending", 4'h4);
      expect_prio("R4 edge source priority", 8'h80);
      lines(8'h00);
      expect_id("R4 pending survives line low", 4'h4);
      take();
      expect_id("R4 taken edge source hidden", SPUR);
      lines(8'h10);
      expect_id("R4 edge while active hidden", SPUR);
      lines(8'h00);
      retire(4'h4);
      expect_id("R4 deact returns to pending", 4'h4);
      take();
      retire(4'h4);
      expect_id("R4 deact of active gives idle", SPUR);
      tick();
      expect_id("R4 stays idle", SPUR);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule